// File: doc/BRIEF.md
# Windowed Video Histogram Generator

This block gathers per-frame statistics from a 32-bit pixel stream in which every pixel carries an alpha byte and three 8-bit colour components. The components may be RGB, YUV or HSV; the block treats them only as channels 0, 1 and 2. Only pixels that fall inside a programmable crop rectangle contribute. Inside that rectangle the pixels can also be thinned out horizontally and vertically by powers of two. For every active channel the block tracks the smallest value, the largest value and a running sum. Each value is also counted into a histogram bin.

Three binning layouts can be selected. The default gives each channel its own 64-bin histogram. A max-component layout folds every pixel down to its largest component and produces one 64-bin histogram. A fine layout produces one 256-bin histogram, which is read through an index/data register pair. Software programs the window, the subsampling and the layout through a small register port. It starts a new collection with a clear write, or implicitly with the start-of-frame pixel. When the frame-done pulse arrives, software reads the results, which stay put until the next clear or frame start. Pixels are accepted on every clock.

Top module: `hist_gen`

## Requirements
- R1: Pixel layout is alpha [31:24], channel 0 [23:16], channel 1 [15:8], channel 2 [7:0]. In the default layout (mode bits 0 and 1 clear), each counted pixel adds one to bin 0x00+c0[7:2], bin 0x40+c1[7:2] and bin 0x80+c2[7:2] of the bin array. Bin array entry i for i below 192 is read directly at register address 0x40+i.
- R2: With mode bit 1 (max-component) set, only the largest of the three components is used. It updates bin 0x40+max[7:2] and the channel 1 statistics. The channel 0 and channel 2 statistics and bins stay at their cleared values.
- R3: With mode bit 0 (fine) set, the channel 1 value (the largest component if bit 1 is also set) is counted into bin array entry equal to its full 8-bit value. Writing an index to register 0x04 and reading register 0x05 returns that entry. Channel 0 and 2 results stay cleared.
- R4: Register 0x01 holds the horizontal offset in [15:0] and the vertical offset in [31:16]. Register 0x02 holds the width in [15:0] and the height in [31:16]. A pixel at column x and line y of the frame is counted only if it lies at or after the offsets and strictly before offset plus size.
- R5: Mode field [5:4] (horizontal) and [9:8] (vertical) give a ratio r. Within the window, only columns and lines whose distance from the offset is a multiple of 2^r are counted, and r=3 behaves as r=2.
- R6: The alpha byte has no effect on any result.
- R7: Registers 0x08, 0x09 and 0x0A read channel 0, 1 and 2 maximum in [23:16] and minimum in [7:0], with all other bits zero. In the cleared state they read maximum 0x00 and minimum 0xFF.
- R8: Registers 0x0C, 0x0D and 0x0E read the channel sums. These saturate at the all-ones value of the counter width instead of wrapping.
- R9: Every bin counter saturates at its all-ones value instead of wrapping.
- R10: Writing 1 to bit 0 of register 0x00, or accepting a pixel flagged start-of-frame, zeroes all bins and sums and sets every max/min to 0x00/0xFF before that cycle's pixel is added. After reset the results are in the cleared state.
- R11: frame_done is high for exactly one cycle, in the cycle after the end-of-line pixel of the last window line is accepted. In that cycle the results of the frame are already final.
- R12: pix_ready is always high, and back-to-back pixels that hit the same bin are each counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present on pix_data |
| pix_ready | output | 1 | Pixel accepted (always high) |
| pix_data | input | 32 | Alpha and three 8-bit components |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| frame_done | output | 1 | One-cycle pulse when results are final |

## Verification
The bench builds the block with a 12-bit coordinate width and a 12-bit counter width instead of the 32-bit default. A narrow counter brings the saturation of both the bins and the sums within reach of a 70 by 70 frame of identical pixels, so R8 and R9 are tested without billions of cycles. The same constant-colour frame sends long runs into the same bin on consecutive clocks. Random frames exercise all three layouts, odd subsampling ratios including the clamped value 3, and windows offset from the frame corner.

// File: rtl/hist_pkg.sv
package hist_pkg;

  localparam int CH_N = 3;

  // largest of three components
  function automatic logic [7:0] max3(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c);
    logic [7:0] m;
    m = (a > b) ? a : b;
    return (c > m) ? c : m;
  endfunction

  // low-bit mask for a subsampling ratio; 3 is clamped to 2
  function automatic logic [1:0] ratio_mask(input logic [1:0] r);
    case (r)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/hist_window.sv
module hist_window import hist_pkg::*; #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic [CW-1:0] hoff,
  input  logic [CW-1:0] voff,
  input  logic [CW-1:0] wid,
  input  logic [CW-1:0] hgt,
  input  logic [1:0]    hratio,
  input  logic [1:0]    vratio,
  output logic          counted,
  output logic          frame_start,
  output logic          win_end
);

  logic [CW-1:0] x_q, y_q, cur_x, cur_y, dx, dy;
  logic          x_in, y_in, keep_x, keep_y;

  always_comb begin
    cur_x  = pix_sof ? '0 : x_q;
    cur_y  = pix_sof ? '0 : y_q;
    dx     = cur_x - hoff;
    dy     = cur_y - voff;
    x_in   = (cur_x >= hoff) && (dx < wid);
    y_in   = (cur_y >= voff) && (dy < hgt);
    keep_x = (dx[1:0] & ratio_mask(hratio)) == 2'b00;
    keep_y = (dy[1:0] & ratio_mask(vratio)) == 2'b00;
    counted     = pix_valid && x_in && y_in && keep_x && keep_y;
    frame_start = pix_valid && pix_sof;
    win_end     = pix_valid && pix_eol && y_in && (dy == hgt - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (pix_valid) begin
      if (pix_eol) begin
        x_q <= '0;
        y_q <= cur_y + 1'b1;
      end else begin
        x_q <= cur_x + 1'b1;
        y_q <= cur_y;
      end
    end
  end

endmodule

// File: rtl/hist_stats.sv
module hist_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [7:0]       val,
  output logic [7:0]       mx_q,
  output logic [7:0]       mn_q,
  output logic [CNT_W-1:0] sum_q
);

  logic [7:0]       bmx, bmn;
  logic [CNT_W-1:0] bsum, sum_nx;
  logic [CNT_W:0]   acc;

  always_comb begin
    bmx    = clr ? 8'h00 : mx_q;
    bmn    = clr ? 8'hFF : mn_q;
    bsum   = clr ? '0 : sum_q;
    acc    = {1'b0, bsum} + {{(CNT_W-7){1'b0}}, val};
    sum_nx = acc[CNT_W] ? '1 : acc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx_q  <= 8'h00;
      mn_q  <= 8'hFF;
      sum_q <= '0;
    end else if (clr || upd) begin
      mx_q  <= (upd && val > bmx) ? val : bmx;
      mn_q  <= (upd && val < bmn) ? val : bmn;
      sum_q <= upd ? sum_nx : bsum;
    end
  end

endmodule

// File: rtl/hist_bins.sv
module hist_bins #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [2:0]       act,
  input  logic [7:0]       idx0,
  input  logic [7:0]       idx1,
  input  logic [7:0]       idx2,
  input  logic [7:0]       rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);

  localparam int NBINS = 256;

  logic [CNT_W-1:0] cnt_q [NBINS];

  for (genvar e = 0; e < NBINS; e++) begin : g_bin
    logic             hit;
    logic [CNT_W-1:0] base, nxt;
    always_comb begin
      hit  = (act[0] && idx0 == 8'(e)) || (act[1] && idx1 == 8'(e)) ||
             (act[2] && idx2 == 8'(e));
      base = clr ? '0 : cnt_q[e];
      nxt  = (&base) ? base : base + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q[e] <= '0;
      else if (clr || hit) cnt_q[e] <= hit ? nxt : base;
    end
  end

  assign rd_cnt = cnt_q[rd_idx];

endmodule

// File: rtl/hist_gen.sv
module hist_gen import hist_pkg::*; #(
  parameter int CW    = 12,
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_valid,
  output logic        pix_ready,
  input  logic [31:0] pix_data,
  input  logic        pix_sof,
  input  logic        pix_eol,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        frame_done
);

  logic [CW-1:0] hoff, voff, wid, hgt;
  logic          fine_q, maxc_q;
  logic [1:0]    hratio, vratio;
  logic [7:0]    bidx;

  logic counted, frame_start, win_end, clr_evt, sw_clear;
  logic [7:0] comp [CH_N];
  logic [7:0] slot_val [CH_N];
  logic [2:0] act;
  logic [7:0] idx0, idx1, idx2, rd_idx;
  logic [CNT_W-1:0] rd_cnt;
  logic [7:0]       mx_w [CH_N];
  logic [7:0]       mn_w [CH_N];
  logic [CNT_W-1:0] sum_w [CH_N];
  logic [7:0]       mx_g, mn_g;
  logic [CNT_W-1:0] sum_g;

  assign pix_ready = 1'b1;
  assign sw_clear  = reg_we && reg_addr == 8'h00 && reg_wdata[0];
  assign clr_evt   = sw_clear || frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hoff <= '0; voff <= '0; wid <= '0; hgt <= '0;
      fine_q <= 1'b0; maxc_q <= 1'b0;
      hratio <= '0; vratio <= '0; bidx <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        8'h01: begin hoff <= reg_wdata[CW-1:0]; voff <= reg_wdata[16+:CW]; end
        8'h02: begin wid <= reg_wdata[CW-1:0];  hgt <= reg_wdata[16+:CW];  end
        8'h03: begin
          fine_q <= reg_wdata[0]; maxc_q <= reg_wdata[1];
          hratio <= reg_wdata[5:4]; vratio <= reg_wdata[9:8];
        end
        8'h04: bidx <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  hist_window #(.CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .hoff(hoff), .voff(voff), .wid(wid), .hgt(hgt),
    .hratio(hratio), .vratio(vratio), .counted(counted),
    .frame_start(frame_start), .win_end(win_end)
  );

  always_comb begin
    comp[0] = pix_data[23:16];
    comp[1] = pix_data[15:8];
    comp[2] = pix_data[7:0];
    slot_val[0] = comp[0];
    slot_val[1] = maxc_q ? max3(comp[0], comp[1], comp[2]) : comp[1];
    slot_val[2] = comp[2];
    act[1] = counted;
    act[0] = counted && !fine_q && !maxc_q;
    act[2] = act[0];
    idx0 = {2'b00, slot_val[0][7:2]};
    idx1 = fine_q ? slot_val[1] : {2'b01, slot_val[1][7:2]};
    idx2 = {2'b10, slot_val[2][7:2]};
    rd_idx = (reg_addr == 8'h05) ? bidx : reg_addr - 8'h40;
  end

  for (genvar s = 0; s < CH_N; s++) begin : g_ch
    hist_stats #(.CNT_W(CNT_W)) u_st (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .upd(act[s]),
      .val(slot_val[s]), .mx_q(mx_w[s]), .mn_q(mn_w[s]), .sum_q(sum_w[s])
    );
  end

  assign mx_g  = mx_w[1];
  assign mn_g  = mn_w[1];
  assign sum_g = sum_w[1];

  hist_bins #(.CNT_W(CNT_W)) u_bins (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .act(act),
    .idx0(idx0), .idx1(idx1), .idx2(idx2), .rd_idx(rd_idx), .rd_cnt(rd_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_done <= 1'b0;
    else        frame_done <= win_end;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr >= 8'h40) reg_rdata = 32'(rd_cnt);
    else begin
      case (reg_addr)
        8'h01: reg_rdata = {16'(voff), 16'(hoff)};
        8'h02: reg_rdata = {16'(hgt), 16'(wid)};
        8'h03: reg_rdata = {22'd0, vratio, 2'd0, hratio, 2'd0, maxc_q, fine_q};
        8'h04: reg_rdata = {24'd0, bidx};
        8'h05: reg_rdata = 32'(rd_cnt);
        8'h08, 8'h09, 8'h0A:
          reg_rdata = {8'h00, mx_w[reg_addr[1:0]], 8'h00, mn_w[reg_addr[1:0]]};
        8'h0C, 8'h0D, 8'h0E: reg_rdata = 32'(sum_w[reg_addr[1:0]]);
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/hist_gen_chk.sv
module hist_gen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             pix_eol,
  input logic             frame_done,
  input logic             clr_evt,
  input logic             counted,
  input logic [7:0]       mx_g,
  input logic [7:0]       mn_g,
  input logic [CNT_W-1:0] sum_g
);

  p_done_after_eol_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(pix_valid && pix_eol));

  p_sum_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |=> sum_g >= $past(sum_g));

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !counted) |=> (sum_g == '0 && mx_g == 8'h00 && mn_g == 8'hFF));

  p_maxmin_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    counted |=> mx_g >= mn_g);

endmodule

bind hist_gen hist_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_eol(pix_eol),
  .frame_done(frame_done), .clr_evt(clr_evt), .counted(counted),
  .mx_g(mx_g), .mn_g(mn_g), .sum_g(sum_g)
);

// File: tb/test_hist_gen.sv
`timescale 1ns/1ps
module test_hist_gen;

  localparam int CW = 12;
  localparam int CNT_W = 12;
  localparam int LIM = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
  logic [31:0] pix_data = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic pix_ready, frame_done;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hist_gen #(.CW(CW), .CNT_W(CNT_W)) i_hist_gen (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frame_done(frame_done)
  );

  // bench model
  int unsigned eb [256];
  int unsigned emx [3], emn [3], esum [3];
  int hoff, voff, wid, hgt, hr, vr;
  bit fine, maxc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int x, input int y);
    int sh, sv;
    sh = 1 << ((hr > 2) ? 2 : hr);
    sv = 1 << ((vr > 2) ? 2 : vr);
    return x >= hoff && x < hoff + wid && y >= voff && y < voff + hgt &&
           ((x - hoff) % sh) == 0 && ((y - voff) % sv) == 0;
  endfunction

  function automatic int unsigned sat_add(input int unsigned a, input int unsigned b);
    return (a + b > LIM) ? LIM : a + b;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 256; i++) eb[i] = 0;
    for (int s = 0; s < 3; s++) begin emx[s] = 0; emn[s] = 255; esum[s] = 0; end
  endtask

  task automatic stat_upd(input int s, input int v);
    if (v > emx[s]) emx[s] = v;
    if (v < emn[s]) emn[s] = v;
    esum[s] = sat_add(esum[s], v);
  endtask

  task automatic model_pix(input logic [31:0] p);
    int c0, c1, c2, v1, bi;
    c0 = p[23:16]; c1 = p[15:8]; c2 = p[7:0];
    v1 = c1;
    if (maxc) begin
      v1 = c0;
      if (c1 > v1) v1 = c1;
      if (c2 > v1) v1 = c2;
    end
    stat_upd(1, v1);
    bi = fine ? v1 : 64 + v1 / 4;
    eb[bi] = sat_add(eb[bi], 1);
    if (!fine && !maxc) begin
      stat_upd(0, c0); stat_upd(2, c2);
      eb[c0 / 4] = sat_add(eb[c0 / 4], 1);
      eb[128 + c2 / 4] = sat_add(eb[128 + c2 / 4], 1);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic configure();
    reg_write(8'h01, {16'(voff), 16'(hoff)});
    reg_write(8'h02, {16'(hgt), 16'(wid)});
    reg_write(8'h03, {22'd0, 2'(vr), 2'd0, 2'(hr), 2'd0, maxc, fine});
  endtask

  // kind 0: random pixel; kind 1: fixed colour with random alpha
  task automatic send_frame(input int w, input int h, input int kind, input string req);
    bit exp_done = 0;
    logic [31:0] p;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        @(negedge clk);
        if (x != 0 || y != 0) chk({req, " R11 done"}, 32'(frame_done), 32'(exp_done));
        p = (kind == 0) ? $urandom : {8'($urandom), 24'hFF8003};
        pix_valid = 1'b1; pix_data = p;
        pix_sof = (x == 0 && y == 0); pix_eol = (x == w - 1);
        if (x == 0 && y == 0) model_clear();
        if (in_win(x, y)) model_pix(p);
        exp_done = (x == w - 1) && (y == voff + hgt - 1);
      end
    end
    @(negedge clk);
    chk({req, " R11 done"}, 32'(frame_done), 32'(exp_done));
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
    @(negedge clk);
    chk("R11 single pulse", 32'(frame_done), 32'd0);
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int s = 0; s < 3; s++) begin
      reg_read(8'(8 + s), d);
      chk({req, " R7 maxmin"}, d, {8'h0, 8'(emx[s]), 8'h0, 8'(emn[s])});
      reg_read(8'(12 + s), d);
      chk({req, " R8 sum"}, d, esum[s]);
    end
    for (int i = 0; i < 192; i++) begin
      reg_read(8'(64 + i), d);
      chk({req, " R1 bin"}, d, eb[i]);
    end
    if (fine) begin
      for (int i = 0; i < 256; i++) begin
        reg_write(8'h04, i);
        reg_read(8'h05, d);
        chk({req, " R3 indexed bin"}, d, eb[i]);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    hoff = 0; voff = 0; wid = 0; hgt = 0; hr = 0; vr = 0; fine = 0; maxc = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R10, R12)
    chk("R12 ready", 32'(pix_ready), 32'd1);
    chk("R11 idle done", 32'(frame_done), 32'd0);
    check_all("reset R10");

    // default layout, offset window (R1, R4, R6)
    hoff = 2; voff = 1; wid = 6; hgt = 4; configure();
    send_frame(10, 7, 0, "R1 R4");
    check_all("R1 R4");

    // max-component with subsampling, ratio 3 clamps (R2, R5)
    hoff = 1; voff = 2; wid = 9; hgt = 6; hr = 1; vr = 3; maxc = 1; configure();
    send_frame(12, 10, 0, "R2 R5");
    check_all("R2 R5");

    // fine 256-bin layout (R3)
    hoff = 0; voff = 0; wid = 16; hgt = 16; hr = 0; vr = 0; maxc = 0; fine = 1;
    configure();
    send_frame(16, 16, 0, "R3");
    check_all("R3");

    // saturation with repeated bin, alpha varies (R8, R9, R12, R6)
    wid = 70; hgt = 70; fine = 0; configure();
    send_frame(70, 70, 1, "R9");
    check_all("R9 R6");
    reg_read(8'h40 + 8'd63, d);
    chk("R9 saturated bin", d, LIM);

    // software clear (R10)
    reg_write(8'h00, 32'd1);
    model_clear();
    check_all("R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule